// File: doc/BRIEF.md
# Interrupt in-service priority tracker

This block sits next to a processor core and decides, cycle by cycle, whether a pending maskable interrupt request may be taken. It keeps an eight-entry in-service vector with one bit per priority level and a global disable flag for maskable requests. A request is accepted when the flag is clear and no level of equal or higher priority is already in service. Acceptance raises a combinational acknowledge strobe that reports the accepted level. At the next clock edge the matching in-service bit is set and the disable flag is raised.

The core reports its own events as single-cycle pulses: disable, enable, a return from a maskable handler, a return from a non-maskable or exception handler, and a write of the 32-bit status word. Both kinds of return and the status-word write load the disable flag from bit 5 of the word they supply. Only a return from a maskable handler removes an in-service bit, and it removes the one with the highest priority. Level 0 has the highest priority and level 7 the lowest.

Top module: `isr_prio_tracker`

## Requirements
- R1: After reset the in-service vector reads 0x00, the disable flag reads 1 (the status word resets to 0x00000020), and ack is 0.
- R2: ack is 1 in a cycle only when req_valid is 1, the disable flag is 0 and no blocking level is in service. ack_level then equals req_level, and after the following clock edge in-service bit req_level is 1.
- R3: The clock edge that ends an ack cycle leaves the disable flag at 1.
- R4: A request presented while the disable flag is 1 is not acknowledged. If it is still presented once the flag has cleared, it is acknowledged in the first cycle in which the flag reads 0.
- R5: A request is blocked while any in-service bit at an index less than or equal to req_level is set. Only a level with a strictly smaller index than every level in service is accepted.
- R6: On ret_maskable the set in-service bit with the lowest index is cleared and all other bits are kept. With an empty vector nothing changes.
- R7: On ret_other the in-service vector is unchanged, and the disable flag takes bit 5 of ret_word.
- R8: di_pulse sets the disable flag and ei_pulse clears it.
- R9: On psw_wr the disable flag takes bit 5 of psw_wdata. All other bits of the word are ignored, and the in-service vector has no write path at all.
- R10: When ret_maskable and a request occur in the same cycle, the return clear is applied first and the eligibility test uses the cleared vector. The acknowledged bit is then set.
- R11: When several events update the flag in one cycle, precedence is: acknowledge, then status-word write, then return (ret_word bit 5), then DI, then EI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A maskable request is pending |
| req_level | input | 3 | Priority level of the pending request, 0 is highest |
| di_pulse | input | 1 | Disable instruction executed |
| ei_pulse | input | 1 | Enable instruction executed |
| ret_maskable | input | 1 | Return from a maskable handler |
| ret_other | input | 1 | Return from a non-maskable or exception handler |
| ret_word | input | 32 | Status word restored by a return |
| psw_wr | input | 1 | Status-word write strobe |
| psw_wdata | input | 32 | Status-word write data |
| ack | output | 1 | Request accepted this cycle |
| ack_level | output | 3 | Level of the accepted request |
| isr | output | 8 | In-service vector, read only |
| dis_flag | output | 1 | Maskable-request disable flag |

## Verification
The acceptance path is driven with three kinds of request, each separating a different cause of refusal. A request held across an enable shows that the flag alone gates it. Equal, lower and higher levels against a busy vector separate the nesting test from the flag. A request that coincides with a return shows whether the clear is ordered before the set. The flag is driven with pairs of simultaneous events to expose its precedence. Returns are applied to vectors with several bits set, with one bit set and with no bit set, which separates clearing the highest-priority bit from clearing any bit or all bits.

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int DEF_LEVELS   = 8;
   localparam int DEF_WORD_W   = 32;
   localparam int DEF_FLAG_BIT = 5;

   // Source that wins the disable-flag update in a cycle
   typedef enum logic [2:0] {
      FSRC_HOLD,
      FSRC_ACK,
      FSRC_WRITE,
      FSRC_RETURN,
      FSRC_DI,
      FSRC_EI
   } flag_src_e;
endpackage

// File: rtl/isr_first_set.sv
// One-hot of the lowest-index (highest-priority) set bit.
module isr_first_set #(
   parameter int N = 8
) (
   input  logic [N-1:0] vec,
   output logic [N-1:0] first_oh
);
   generate
      if (N < 2) begin : g_bad_n
         $error("isr_first_set: N must be at least 2");
      end
   endgenerate

   assign first_oh = vec & (~vec + N'(1));
endmodule

// File: rtl/isr_level_block.sv
// Reports whether any set bit sits at an index at or below a level.
module isr_level_block #(
   parameter int N  = 8,
   localparam int LW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [LW-1:0] lvl,
   output logic          blocked
);
   logic [N-1:0] at_or_above;

   generate
      for (genvar g = 0; g < N; g++) begin : g_mask
         assign at_or_above[g] = (lvl >= LW'(g));
      end
   endgenerate

   assign blocked = |(vec & at_or_above);
endmodule

// File: rtl/isr_dis_flag.sv
// Disable-flag register with fixed update precedence.
module isr_dis_flag
   import isr_pkg::*;
#(
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic ret_en,
   input  logic ret_bit,
   input  logic di,
   input  logic ei,
   output logic flag
);
   flag_src_e src;
   logic      flag_d;

   always_comb begin
      if (take)        src = FSRC_ACK;
      else if (wr_en)  src = FSRC_WRITE;
      else if (ret_en) src = FSRC_RETURN;
      else if (di)     src = FSRC_DI;
      else if (ei)     src = FSRC_EI;
      else             src = FSRC_HOLD;
   end

   always_comb begin
      unique case (src)
         FSRC_ACK:    flag_d = 1'b1;
         FSRC_WRITE:  flag_d = wr_bit;
         FSRC_RETURN: flag_d = ret_bit;
         FSRC_DI:     flag_d = 1'b1;
         FSRC_EI:     flag_d = 1'b0;
         default:     flag_d = flag;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= RST_VAL;
      else        flag <= flag_d;
   end
endmodule

// File: rtl/isr_prio_tracker.sv
module isr_prio_tracker #(
   parameter int          LEVELS   = isr_pkg::DEF_LEVELS,
   parameter int          WORD_W   = isr_pkg::DEF_WORD_W,
   parameter int          FLAG_BIT = isr_pkg::DEF_FLAG_BIT,
   parameter logic [31:0] RST_WORD = 32'h0000_0020,
   localparam int         LW       = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [LW-1:0]     req_level,
   input  logic              di_pulse,
   input  logic              ei_pulse,
   input  logic              ret_maskable,
   input  logic              ret_other,
   input  logic [WORD_W-1:0] ret_word,
   input  logic              psw_wr,
   input  logic [WORD_W-1:0] psw_wdata,
   output logic              ack,
   output logic [LW-1:0]     ack_level,
   output logic [LEVELS-1:0] isr,
   output logic              dis_flag
);
   generate
      if (FLAG_BIT >= WORD_W) begin : g_bad_bit
         $error("isr_prio_tracker: FLAG_BIT outside status word");
      end
      if ((1 << LW) != LEVELS) begin : g_bad_levels
         $error("isr_prio_tracker: LEVELS must be a power of two");
      end
   endgenerate

   logic [LEVELS-1:0] isr_q, isr_d, top_oh, isr_cleared, set_oh;
   logic              blocked;
   logic              unused_word_bits;

   assign unused_word_bits = ^{ret_word, psw_wdata};

   isr_first_set #(.N(LEVELS)) u_first (
      .vec      (isr_q),
      .first_oh (top_oh)
   );

   // Return clear is applied before the eligibility test
   assign isr_cleared = ret_maskable ? (isr_q & ~top_oh) : isr_q;

   isr_level_block #(.N(LEVELS)) u_block (
      .vec     (isr_cleared),
      .lvl     (req_level),
      .blocked (blocked)
   );

   assign ack       = req_valid & ~dis_flag & ~blocked;
   assign ack_level = req_level;

   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_set
         assign set_oh[g] = ack & (req_level == LW'(g));
      end
   endgenerate

   assign isr_d = isr_cleared | set_oh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end

   assign isr = isr_q;

   isr_dis_flag #(.RST_VAL(RST_WORD[FLAG_BIT])) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (ack),
      .wr_en   (psw_wr),
      .wr_bit  (psw_wdata[FLAG_BIT]),
      .ret_en  (ret_maskable | ret_other),
      .ret_bit (ret_word[FLAG_BIT]),
      .di      (di_pulse),
      .ei      (ei_pulse),
      .flag    (dis_flag)
   );
endmodule

// File: rtl/isr_prio_tracker_chk.sv
module isr_prio_tracker_chk #(
   parameter int  LEVELS = 8,
   localparam int LW     = $clog2(LEVELS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              di_pulse,
   input logic              ret_maskable,
   input logic              ret_other,
   input logic              psw_wr,
   input logic              ack,
   input logic [LW-1:0]     ack_level,
   input logic [LEVELS-1:0] isr,
   input logic              dis_flag
);
   logic busy_at_or_above;
   always_comb begin
      busy_at_or_above = 1'b0;
      for (int i = 0; i < LEVELS; i++)
         if (isr[i] && (i <= int'(ack_level))) busy_at_or_above = 1'b1;
   end

   // R2
   a_r2_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !dis_flag);
   // R2
   a_r2_ack_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> isr[$past(ack_level)]);
   // R3
   a_r3_ack_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> dis_flag);
   // R5
   a_r5_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ret_maskable) |-> !busy_at_or_above);
   // R6
   a_r6_ret_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_maskable && !ack && (isr != '0)) |=>
         ($countones(isr) == $countones($past(isr)) - 1));
   // R7
   a_r7_other_ret_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_other && !ret_maskable && !ack) |=> (isr == $past(isr)));
   // R8
   a_r8_di_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (di_pulse && !psw_wr && !ret_maskable && !ret_other) |=> dis_flag);
endmodule

bind isr_prio_tracker isr_prio_tracker_chk #(.LEVELS(LEVELS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .di_pulse     (di_pulse),
   .ret_maskable (ret_maskable),
   .ret_other    (ret_other),
   .psw_wr       (psw_wr),
   .ack          (ack),
   .ack_level    (ack_level),
   .isr          (isr),
   .dis_flag     (dis_flag)
);

// File: tb/isr_prio_tracker_tb.sv
module isr_prio_tracker_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_level = '0;
   logic        di_pulse = 1'b0, ei_pulse = 1'b0;
   logic        ret_maskable = 1'b0, ret_other = 1'b0;
   logic [31:0] ret_word = '0;
   logic        psw_wr = 1'b0;
   logic [31:0] psw_wdata = '0;
   logic        ack;
   logic [2:0]  ack_level;
   logic [7:0]  isr;
   logic        dis_flag;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   isr_prio_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
      .di_pulse(di_pulse), .ei_pulse(ei_pulse), .ret_maskable(ret_maskable),
      .ret_other(ret_other), .ret_word(ret_word), .psw_wr(psw_wr),
      .psw_wdata(psw_wdata), .ack(ack), .ack_level(ack_level), .isr(isr),
      .dis_flag(dis_flag)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Advance one edge; leave at the next falling edge with pulses cleared
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      di_pulse = 0; ei_pulse = 0; ret_maskable = 0; ret_other = 0; psw_wr = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 isr", 32'(isr), 32'h00);
      chk("R1 dis_flag", 32'(dis_flag), 32'h1);
      chk("R1 ack", 32'(ack), 32'h0);
   endtask

   task automatic t_held_request();
      req_valid = 1; req_level = 3;
      #1 chk("R4 blocked while flag set", 32'(ack), 0);
      step();
      ei_pulse = 1;
      #1 chk("R4 still blocked during EI cycle", 32'(ack), 0);
      step();
      #1 chk("R4 taken once flag clears", 32'(ack), 1);
      chk("R2 ack_level", 32'(ack_level), 3);
      step();
      req_valid = 0;
      #1 chk("R2 isr bit set", 32'(isr), 32'h08);
      chk("R3 flag set by ack", 32'(dis_flag), 1);
   endtask

   task automatic t_nesting();
      ei_pulse = 1;
      step();
      req_valid = 1; req_level = 3;
      #1 chk("R5 equal level refused", 32'(ack), 0);
      req_level = 5;
      #1 chk("R5 lower priority refused", 32'(ack), 0);
      req_level = 1;
      #1 chk("R5 higher priority taken", 32'(ack), 1);
      step();
      req_valid = 0;
      #1 chk("R5 nested isr", 32'(isr), 32'h0A);
   endtask

   task automatic t_other_return();
      ret_other = 1; ret_word = 32'h0;
      step();
      #1 chk("R7 isr kept", 32'(isr), 32'h0A);
      chk("R7 flag from ret_word", 32'(dis_flag), 0);
   endtask

   task automatic t_status_write();
      psw_wr = 1; psw_wdata = 32'h0000_0020;
      step();
      #1 chk("R9 flag written 1", 32'(dis_flag), 1);
      chk("R9 isr unaffected", 32'(isr), 32'h0A);
      psw_wr = 1; psw_wdata = 32'hFFFF_FFDF;
      step();
      #1 chk("R9 flag written 0, other bits ignored", 32'(dis_flag), 0);
      chk("R9 isr still unaffected", 32'(isr), 32'h0A);
   endtask

   task automatic t_maskable_return();
      ret_maskable = 1; ret_word = 32'h0;
      step();
      #1 chk("R6 highest-priority bit cleared", 32'(isr), 32'h08);
   endtask

   task automatic t_return_with_ack();
      req_valid = 1; req_level = 3; ret_maskable = 1; ret_word = 32'h0;
      #1 chk("R10 ack after clear", 32'(ack), 1);
      step();
      req_valid = 0;
      #1 chk("R10 isr clear then set", 32'(isr), 32'h08);
      chk("R11 ack beats return load", 32'(dis_flag), 1);
   endtask

   task automatic t_flag_precedence();
      ei_pulse = 1;
      step();
      #1 chk("R8 EI clears", 32'(dis_flag), 0);
      di_pulse = 1; ei_pulse = 1;
      step();
      #1 chk("R11 DI beats EI", 32'(dis_flag), 1);
      psw_wr = 1; psw_wdata = 32'h0; di_pulse = 1;
      step();
      #1 chk("R11 write beats DI", 32'(dis_flag), 0);
      ret_other = 1; ret_word = 32'h20; ei_pulse = 1;
      step();
      #1 chk("R11 return beats EI", 32'(dis_flag), 1);
      di_pulse = 1;
      step();
      #1 chk("R8 DI sets", 32'(dis_flag), 1);
   endtask

   task automatic t_empty_return();
      ret_maskable = 1; ret_word = 32'h0;
      step();
      #1 chk("R6 last bit cleared", 32'(isr), 32'h00);
      ret_maskable = 1; ret_word = 32'h0;
      step();
      #1 chk("R6 empty vector unchanged", 32'(isr), 32'h00);
   endtask

   task automatic t_extremes();
      req_valid = 1; req_level = 7;
      #1 chk("R2 level 7 taken on empty", 32'(ack), 1);
      step();
      req_valid = 0;
      #1 chk("R2 isr level 7", 32'(isr), 32'h80);
      ei_pulse = 1;
      step();
      req_valid = 1; req_level = 0;
      #1 chk("R5 level 0 preempts", 32'(ack), 1);
      step();
      req_valid = 0;
      #1 chk("R5 isr 0x81", 32'(isr), 32'h81);
      ret_maskable = 1; ret_word = 32'h0;
      step();
      #1 chk("R6 level 0 cleared first", 32'(isr), 32'h80);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_held_request();
      t_nesting();
      t_other_return();
      t_status_write();
      t_maskable_return();
      t_return_with_ack();
      t_flag_precedence();
      t_empty_return();
      t_extremes();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule